// File: doc/BRIEF.md
# Single-Wire Frame Transmitter with Collision Detect

This block sends bytes over one shared data line that has a pull-up and may also be driven by a remote party. Each byte leaves as a fixed-length serial frame. A zero is always driven low. A one is driven high only for the first bit period of a run of ones. For the later ones of the run the driver lets go and the pull-up holds the line high.

While the driver is released, the transmitter reads the line once in the middle of every bit period. If the line reads low at that point, another party is pulling it down. The frame is then abandoned at once: the pin is released, a one-cycle collision pulse is raised to the layer above, and the block refuses new bytes until that layer explicitly sends it back to idle. Streams of zeros, or of strictly alternating bits, never release the driver, so they cannot reveal a collision. The high stop bits at the end of each frame guarantee at least one released bit per frame.

Top module: `swtx_tx_cd`

## Requirements
- R1: After reset, tx_ready is 1, drv_en is 0 and coll_pulse is 0. A reset in the middle of a frame ends it the same way.
- R2: An accepted byte is sent as 12 bit periods of CLKS_PER_BIT clocks each (default 8). Frame position 0 is the start bit (0). Positions 1 to 8 hold the data bits, least significant bit first. Position 9 is the even-parity bit, equal to the XOR of the data bits. Positions 10 and 11 are stop bits (1). Bit 0 begins in the cycle after the handshake edge.
- R3: During a zero bit, drv_en is 1 and drv_val is 0 for the whole bit period.
- R4: A one bit whose preceding frame bit is zero is driven (drv_en 1, drv_val 1) for its whole period. A one bit whose preceding bit is also one is released (drv_en 0).
- R5: The line is read at clock count CLKS_PER_BIT/2 within each bit period. A low reading there is a collision only if the driver is released. A low level during a driven bit is ignored.
- R6: On a collision, coll_pulse is 1 for exactly one cycle, in the cycle after the sampling edge. From that same cycle on, drv_en is 0 and tx_ready is 0.
- R7: After a collision the block stays in its error state, with tx_ready 0 and drv_en 0, and tx_valid is ignored. This lasts until recover is sampled high. The cycle after that edge, tx_ready is 1.
- R8: tx_ready is 0 from the handshake until the last stop bit ends, and tx_valid is ignored during that time. tx_ready is 1 in the cycle after the frame's final clock.
- R9: While idle, the driver is released (drv_en 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte accepted when high together with tx_valid |
| line_in | input | 1 | Sensed level of the shared line |
| drv_en | output | 1 | Pin driver enable |
| drv_val | output | 1 | Level driven when enabled |
| recover | input | 1 | Returns the block from the error state to idle |
| coll_pulse | output | 1 | One-cycle collision report |

## Verification
The embedded assertions check the pin rules on every cycle: zeros are pulled low, repeated ones are released, and idle and error states never drive. They also check that a collision pulse follows only a released, low reading, lasts one cycle and leaves the pin released, and that the error state holds until recover. Frame content and bit order, the placement of the mid-bit sample, and collision injection at chosen positions can only be shown by the bench scenarios. The same applies to completion timing, ignoring of offers while busy or in error, and reset in the middle of a frame. Those scenarios also confirm that low levels placed on driven bits stay unflagged.

// File: rtl/swtx_pkg.sv
package swtx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SEND  = 2'd1,
        TX_ABORT = 2'd2
    } txst_e;

    typedef struct packed {
        logic en;
        logic val;
    } pin_drive_t;

endpackage

// File: rtl/swtx_framer.sv
module swtx_framer #(
    parameter int DATA_W  = 8,
    parameter int STOP_W  = 2,
    parameter int FRAME_W = DATA_W + 2 + STOP_W
) (
    input  logic [DATA_W-1:0]  data,
    output logic [FRAME_W-1:0] frame
);
    localparam int PAR_POS  = DATA_W + 1;
    localparam int STOP_POS = DATA_W + 2;

    // start bit is a low level
    assign frame[0] = 1'b0;

    // payload, least significant bit leaves first
    for (genvar i = 0; i < DATA_W; i++) begin : g_data
        assign frame[1 + i] = data[i];
    end

    // even parity over the payload
    assign frame[PAR_POS] = ^data;

    for (genvar s = 0; s < STOP_W; s++) begin : g_stop
        assign frame[STOP_POS + s] = 1'b1;
    end

endmodule

// File: rtl/swtx_bit_clock.sv
module swtx_bit_clock #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mid_tick,
    output logic last_tick
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] MID_CNT  = CW'(CLKS_PER_BIT / 2);
    localparam logic [CW-1:0] LAST_CNT = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST_CNT) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign mid_tick  = run && (cnt_q == MID_CNT);
    assign last_tick = run && (cnt_q == LAST_CNT);

    AST_CNT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/swtx_pin_ctrl.sv
module swtx_pin_ctrl
    import swtx_pkg::*;
(
    input  logic       active,
    input  logic       cur_bit,
    input  logic       prev_bit,
    output pin_drive_t drive
);
    // a zero is always driven; a one only when it opens a run of ones
    always_comb begin
        drive.en  = active && (!cur_bit || !prev_bit);
        drive.val = cur_bit;
    end

endmodule

// File: rtl/swtx_tx_cd.sv
module swtx_tx_cd
    import swtx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int DATA_W       = 8,
    parameter int STOP_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              line_in,
    output logic              drv_en,
    output logic              drv_val,
    input  logic              recover,
    output logic              coll_pulse
);
    localparam int FRAME_W = DATA_W + 2 + STOP_W;
    localparam int LW      = $clog2(FRAME_W);
    localparam logic [LW-1:0] LAST_IDX = LW'(FRAME_W - 1);

    typedef struct packed {
        txst_e              state;
        logic [FRAME_W-1:0] sh;
        logic               prev;
        logic [LW-1:0]      left;
        logic               coll;
    } regs_t;

    regs_t r_d, r_q;

    logic [FRAME_W-1:0] frame_w;
    logic               mid_tick, last_tick;
    pin_drive_t         drive;
    logic               sending;

    assign sending = (r_q.state == TX_SEND);

    swtx_framer #(
        .DATA_W (DATA_W),
        .STOP_W (STOP_W),
        .FRAME_W(FRAME_W)
    ) u_framer (
        .data (tx_data),
        .frame(frame_w)
    );

    swtx_bit_clock #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sending),
        .mid_tick (mid_tick),
        .last_tick(last_tick)
    );

    swtx_pin_ctrl u_pin (
        .active  (sending),
        .cur_bit (r_q.sh[0]),
        .prev_bit(r_q.prev),
        .drive   (drive)
    );

    always_comb begin
        r_d      = r_q;
        r_d.coll = 1'b0;
        unique case (r_q.state)
            TX_IDLE: begin
                if (tx_valid) begin
                    r_d.state = TX_SEND;
                    r_d.sh    = frame_w;
                    r_d.prev  = 1'b1;
                    r_d.left  = LAST_IDX;
                end
            end
            TX_SEND: begin
                if (mid_tick && !drive.en && !line_in) begin
                    r_d.state = TX_ABORT;
                    r_d.coll  = 1'b1;
                end else if (last_tick) begin
                    if (r_q.left == '0) begin
                        r_d.state = TX_IDLE;
                    end else begin
                        r_d.prev = r_q.sh[0];
                        r_d.sh   = r_q.sh >> 1;
                        r_d.left = r_q.left - 1'b1;
                    end
                end
            end
            TX_ABORT: begin
                if (recover) r_d.state = TX_IDLE;
            end
            default: r_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= TX_IDLE;
            r_q.sh    <= '1;
            r_q.prev  <= 1'b1;
            r_q.left  <= '0;
            r_q.coll  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ready   = (r_q.state == TX_IDLE);
    assign drv_en     = drive.en;
    assign drv_val    = drive.val;
    assign coll_pulse = r_q.coll;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == TX_IDLE) |-> !drv_en); // R9
    AST_ZERO_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && !r_q.sh[0]) |-> (drv_en && !drv_val)); // R3
    AST_RUN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && r_q.sh[0] && r_q.prev) |-> !drv_en); // R4
    AST_COLL_FROM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        coll_pulse |-> $past(!drv_en && !line_in && sending)); // R5
    AST_COLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        coll_pulse |=> !coll_pulse); // R6
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        coll_pulse |-> (!drv_en && !tx_ready)); // R6
    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == TX_ABORT && !recover) |=> (r_q.state == TX_ABORT)); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != TX_IDLE) |-> !tx_ready); // R8

endmodule

// File: tb/sim_swtx_tx_cd.sv
`timescale 1ns/100ps
module sim_swtx_tx_cd;
    localparam int CPB  = 8;
    localparam int HALF = CPB / 2;
    localparam int NBIT = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       drv_en, drv_val;
    logic       recover = 1'b0;
    logic       coll_pulse;
    logic       ext_low = 1'b0;
    logic       line_in;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // pull-up plus remote pull-down; an enabled driver sets the level it drives
    assign line_in = (drv_en ? drv_val : 1'b1) & ~ext_low;

    swtx_tx_cd #(.CLKS_PER_BIT(CPB)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .line_in(line_in), .drv_en(drv_en),
        .drv_val(drv_val), .recover(recover), .coll_pulse(coll_pulse)
    );

    // {expect collision, forced-low frame position (15 = none), byte}
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 4'd15, 8'h00},
        {1'b0, 4'd15, 8'hFF},
        {1'b1, 4'd3,  8'hFF},
        {1'b0, 4'd5,  8'h55},
        {1'b1, 4'd11, 8'h00},
        {1'b1, 4'd10, 8'h01},
        {1'b0, 4'd0,  8'hF0},
        {1'b1, 4'd4,  8'h0F}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [NBIT-1:0] build(input logic [7:0] d);
        logic [NBIT-1:0] f;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[1 + i] = d[i];
        f[9]  = ^d;
        f[10] = 1'b1;
        f[11] = 1'b1;
        return f;
    endfunction

    task automatic run_frame(input logic [7:0] d, input int inj, input bit tbl_coll);
        logic [NBIT-1:0] f;
        bit hit, want;
        f = build(d);
        want = (inj < NBIT) && f[inj] && (inj > 0) && f[inj-1];
        check("R5 vector table agrees with frame rule", 32'(want), 32'(tbl_coll));
        hit = 1'b0;
        @(negedge clk);
        check("R8 ready before offer", 32'(tx_ready), 32'd1);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        for (int k = 0; k < NBIT; k++) begin
            for (int c = 0; c < CPB; c++) begin
                bit exp_en;
                if (!(k == 0 && c == 0)) @(negedge clk);
                exp_en = !f[k] || (k > 0 && !f[k-1]);
                if (c == 0) ext_low = (k == inj);
                if (c == 1) begin
                    check(f[k] ? "R4 enable for one bit" : "R3 enable for zero bit",
                          32'(drv_en), 32'(exp_en));
                    if (exp_en) check("R2 driven level", 32'(drv_val), 32'(f[k]));
                    check("R8 busy not ready", 32'(tx_ready), 32'd0);
                end
                if (c == HALF + 1 && k == inj) begin
                    check("R5 collision flagged only when released",
                          32'(coll_pulse), 32'(!exp_en));
                    if (!exp_en) begin
                        check("R6 pin released on abort", 32'(drv_en), 32'd0);
                        check("R6 not ready on abort", 32'(tx_ready), 32'd0);
                        hit = 1'b1;
                    end
                end
                if (hit) break;
            end
            if (hit) break;
        end
        ext_low = 1'b0;
        if (hit) begin
            @(negedge clk);
            check("R6 pulse lasts one cycle", 32'(coll_pulse), 32'd0);
            tx_data  = 8'h00;
            tx_valid = 1'b1;
            repeat (10) @(negedge clk);
            check("R7 error holds ready low", 32'(tx_ready), 32'd0);
            check("R7 error keeps pin released", 32'(drv_en), 32'd0);
            tx_valid = 1'b0;
            recover  = 1'b1;
            @(negedge clk);
            recover = 1'b0;
            check("R7 ready after recover", 32'(tx_ready), 32'd1);
        end else begin
            @(negedge clk);
            check("R8 ready after last stop bit", 32'(tx_ready), 32'd1);
            check("R9 idle released", 32'(drv_en), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready in reset", 32'(tx_ready), 32'd1);
        check("R1 released in reset", 32'(drv_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 32'(tx_ready), 32'd1);
        check("R1 no collision after reset", 32'(coll_pulse), 32'd0);
        check("R9 idle released", 32'(drv_en), 32'd0);

        for (int v = 0; v < 8; v++) begin
            run_frame(VEC[v][7:0], int'(VEC[v][11:8]), VEC[v][12]);
        end

        // R8: offers while busy are ignored
        @(negedge clk);
        tx_data  = 8'h3C;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (20) @(negedge clk);
        tx_data  = 8'h00;
        tx_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 not ready mid frame", 32'(tx_ready), 32'd0);
        tx_valid = 1'b0;
        repeat (NBIT * CPB - 23) @(negedge clk);
        check("R8 ready after frame", 32'(tx_ready), 32'd1);
        repeat (5) @(negedge clk);
        check("R8 no second frame from busy offer", 32'(drv_en), 32'd0);

        // R1: reset in the middle of a frame
        tx_data  = 8'h00;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (10) @(negedge clk);
        check("R3 zero data bit driven", 32'(drv_en), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid frame releases pin", 32'(drv_en), 32'd0);
        check("R1 reset mid frame ready", 32'(tx_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule